// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sequences the entry into an exception handler and the return from it in a 32-bit processor core. When the core raises an exception it presents a 6-bit cause code, a 2-bit sub-cause for program exceptions, the current instruction address and the current machine state register (MSR). The sequencer stores a return address and a cause-tagged copy of the MSR in two save registers. It then produces a fresh MSR and the handler address, which comes from a writable per-cause vector table ORed with a writable base prefix.

A return request reloads the instruction address and the MSR from the save registers. Every update is presented for one cycle on `upd_o`, and the core then loads `pc_o` and `msr_o`. The vector table and the prefix are filled through a small write port before use.

Top module: `exc_seq`

## Requirements
- R1: On entry, `save_msr_o` holds the incoming MSR with the bits in mask 0x783F0000 cleared. Only the program cause (code 6) then ORs cause bits into it.
- R2: On entry, the new MSR is zero except for two bits. ME (bit 12) is copied from the old MSR, except on a machine check. LE (bit 0) is set when the old MSR has ILE (bit 16) set.
- R3: Three causes save the faulting address (`pc_i` - 4) in `save_pc_o`: alignment (code 5), program (code 6) and FP-unavailable (code 7). The one exception is a floating-point program exception with FE0 equal to FE1. Every other cause saves `pc_i`.
- R4: Program sub-causes add bits to the saved MSR. Sub-cause 0 (FP enabled) adds 0x00100000. Sub-cause 1 (illegal) adds 0x00080000. Sub-cause 2 (privileged) adds 0x00040000. Sub-cause 3 (trap) adds 0x00020000. For sub-cause 0 with FE0 (bit 11) different from FE1 (bit 8), bit 0x00010000 is also added.
- R5: A floating-point program exception (code 6, sub-cause 0) is dropped in two cases: FP (bit 13) is 0, or FE0 and FE1 are both 0. A dropped request produces no update pulse and leaves the save registers unchanged.
- R6: A machine check (code 1) clears ME in the new MSR. If ME was 0 in the incoming MSR, `halt_o` rises and stays high until reset.
- R7: The handler address on `pc_o` is the table entry for the cause ORed with the prefix. A write with `cfg_addr_i[6]` = 0 targets table entry `cfg_addr_i[5:0]`, and a write with `cfg_addr_i[6]` = 1 targets the prefix. An all-ones entry raises `vec_err_o` together with the update.
- R8: On return, `pc_o` = `save_pc_o` with bits 1:0 cleared, and `msr_o` = `save_msr_o` with mask 0x783F0000 cleared. The save registers keep their values.
- R9: An accepted request produces `upd_o` and `busy_o` high for exactly the following cycle, and requests during that cycle are ignored. An entry request wins over a simultaneous return request.
- R10: After reset, all outputs are zero, every table entry is all ones and the prefix is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception entry request |
| exc_cause_i | input | 6 | Cause code |
| exc_sub_i | input | 2 | Program exception sub-cause |
| ret_req_i | input | 1 | Return-from-interrupt request |
| pc_i | input | 32 | Current instruction address |
| msr_i | input | 32 | Current MSR |
| cfg_we_i | input | 1 | Table/prefix write enable |
| cfg_addr_i | input | 7 | Write address, bit 6 selects the prefix |
| cfg_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Update in progress, requests ignored |
| upd_o | output | 1 | New PC and MSR valid this cycle |
| pc_o | output | 32 | New instruction address |
| msr_o | output | 32 | New MSR |
| save_pc_o | output | 32 | Save register 0 (return address) |
| save_msr_o | output | 32 | Save register 1 (saved MSR) |
| vec_err_o | output | 1 | Undefined vector used on this update |
| halt_o | output | 1 | Checkstop state |

## Verification
Some properties are checked by the assertions on every cycle. The update pulse is one cycle wide, and a checkstop stays until reset. After any entry the new MSR contains only the ME and LE bits, and a machine check always leaves ME clear. Outside program causes the masked MSR bits are clear in the saved copy, a return produces a word-aligned address, and a vector error only appears with an update. The bench scenarios are needed for the rest: the exact sub-cause bit patterns, the choice between the faulting and the next address, dropped floating-point exceptions, the vector and prefix arithmetic, and the value restored on return.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] C_MCHK  = 6'd1;
  localparam logic [5:0] C_DSI   = 6'd2;
  localparam logic [5:0] C_ISI   = 6'd3;
  localparam logic [5:0] C_EXT   = 6'd4;
  localparam logic [5:0] C_ALIGN = 6'd5;
  localparam logic [5:0] C_PROG  = 6'd6;
  localparam logic [5:0] C_FPU   = 6'd7;

  localparam int B_LE  = 0;
  localparam int B_FE1 = 8;
  localparam int B_FE0 = 11;
  localparam int B_ME  = 12;
  localparam int B_FP  = 13;
  localparam int B_ILE = 16;

  localparam logic [XLEN-1:0] SAVE_CLR = 32'h783F_0000;
  localparam logic [XLEN-1:0] P_FPEN   = 32'h0010_0000;
  localparam logic [XLEN-1:0] P_ILL    = 32'h0008_0000;
  localparam logic [XLEN-1:0] P_PRIV   = 32'h0004_0000;
  localparam logic [XLEN-1:0] P_TRAP   = 32'h0002_0000;
  localparam logic [XLEN-1:0] P_IMPR   = 32'h0001_0000;

  typedef enum logic [1:0] {
    SUB_FP   = 2'd0,
    SUB_ILL  = 2'd1,
    SUB_PRIV = 2'd2,
    SUB_TRAP = 2'd3
  } prog_sub_e;
endpackage

// File: rtl/exc_vec_table.sv
module exc_vec_table
  import exc_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [CAUSE_W:0]   addr_i,
  input  logic [XLEN-1:0]    wdata_i,
  input  logic [CAUSE_W-1:0] idx_i,
  output logic [XLEN-1:0]    vec_o,
  output logic [XLEN-1:0]    prefix_o
);
  localparam int NVEC = 1 << CAUSE_W;

  logic [XLEN-1:0] tab_q [NVEC];
  logic [XLEN-1:0] prefix_q;

  for (genvar g = 0; g < NVEC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tab_q[g] <= '1;
      else if (we_i && !addr_i[CAUSE_W] && addr_i[CAUSE_W-1:0] == CAUSE_W'(g))
        tab_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      prefix_q <= '0;
    else if (we_i && addr_i[CAUSE_W])
      prefix_q <= wdata_i;
  end

  assign vec_o    = tab_q[idx_i];
  assign prefix_o = prefix_q;
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         sub_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    msr_i,
  output logic [XLEN-1:0]    save_pc_o,
  output logic [XLEN-1:0]    save_msr_o,
  output logic [XLEN-1:0]    new_msr_o,
  output logic               drop_o,
  output logic               chkstop_o
);
  logic use_cur;
  logic fe_on, fe_mixed;

  assign fe_on    = msr_i[B_FE0] | msr_i[B_FE1];
  assign fe_mixed = msr_i[B_FE0] ^ msr_i[B_FE1];

  always_comb begin
    save_msr_o = msr_i & ~SAVE_CLR;
    new_msr_o  = '0;
    new_msr_o[B_ME] = msr_i[B_ME];
    new_msr_o[B_LE] = msr_i[B_ILE];
    use_cur    = 1'b0;
    drop_o     = 1'b0;
    chkstop_o  = 1'b0;
    unique case (6'(cause_i))
      C_MCHK: begin
        new_msr_o[B_ME] = 1'b0;
        chkstop_o       = ~msr_i[B_ME];
      end
      C_ALIGN, C_FPU: use_cur = 1'b1;
      C_PROG: begin
        unique case (prog_sub_e'(sub_i))
          SUB_FP: begin
            drop_o     = ~msr_i[B_FP] | ~fe_on;
            save_msr_o = save_msr_o | P_FPEN | (fe_mixed ? P_IMPR : '0);
            use_cur    = fe_mixed;
          end
          SUB_ILL: begin
            save_msr_o = save_msr_o | P_ILL;
            use_cur    = 1'b1;
          end
          SUB_PRIV: begin
            save_msr_o = save_msr_o | P_PRIV;
            use_cur    = 1'b1;
          end
          default: begin
            save_msr_o = save_msr_o | P_TRAP;
            use_cur    = 1'b1;
          end
        endcase
      end
      default: ;
    endcase
    save_pc_o = use_cur ? pc_i - XLEN'(4) : pc_i;
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [1:0]         exc_sub_i,
  input  logic               ret_req_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    msr_i,
  input  logic               cfg_we_i,
  input  logic [CAUSE_W:0]   cfg_addr_i,
  input  logic [XLEN-1:0]    cfg_wdata_i,
  output logic               busy_o,
  output logic               upd_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    msr_o,
  output logic [XLEN-1:0]    save_pc_o,
  output logic [XLEN-1:0]    save_msr_o,
  output logic               vec_err_o,
  output logic               halt_o
);
  logic [XLEN-1:0] vec, prefix, c_spc, c_smsr, c_nmsr;
  logic            c_drop, c_chk;
  logic            take_exc, take_ret;
  logic [XLEN-1:0] pc_q, msr_q, spc_q, smsr_q;
  logic            upd_q, verr_q, halt_q;

  exc_vec_table #(.CAUSE_W(CAUSE_W)) u_tab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .idx_i    (exc_cause_i),
    .vec_o    (vec),
    .prefix_o (prefix)
  );

  exc_entry_calc #(.CAUSE_W(CAUSE_W)) u_calc (
    .cause_i    (exc_cause_i),
    .sub_i      (exc_sub_i),
    .pc_i       (pc_i),
    .msr_i      (msr_i),
    .save_pc_o  (c_spc),
    .save_msr_o (c_smsr),
    .new_msr_o  (c_nmsr),
    .drop_o     (c_drop),
    .chkstop_o  (c_chk)
  );

  // entry beats return; a dropped entry also suppresses the return
  assign take_exc = exc_req_i & ~upd_q & ~c_drop;
  assign take_ret = ret_req_i & ~exc_req_i & ~upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      msr_q  <= '0;
      spc_q  <= '0;
      smsr_q <= '0;
      upd_q  <= 1'b0;
      verr_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      upd_q  <= take_exc | take_ret;
      verr_q <= 1'b0;
      if (take_exc) begin
        spc_q  <= c_spc;
        smsr_q <= c_smsr;
        msr_q  <= c_nmsr;
        pc_q   <= vec | prefix;
        verr_q <= &vec;
        if (c_chk) halt_q <= 1'b1;
      end else if (take_ret) begin
        pc_q  <= {spc_q[XLEN-1:2], 2'b00};
        msr_q <= smsr_q & ~SAVE_CLR;
      end
    end
  end

  assign busy_o     = upd_q;
  assign upd_o      = upd_q;
  assign pc_o       = pc_q;
  assign msr_o      = msr_q;
  assign save_pc_o  = spc_q;
  assign save_msr_o = smsr_q;
  assign vec_err_o  = verr_q;
  assign halt_o     = halt_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               exc_req_i,
  input logic [CAUSE_W-1:0] exc_cause_i,
  input logic               ret_req_i,
  input logic               busy_o,
  input logic               upd_o,
  input logic [XLEN-1:0]    pc_o,
  input logic [XLEN-1:0]    msr_o,
  input logic [XLEN-1:0]    save_msr_o,
  input logic               vec_err_o,
  input logic               halt_o
);
  localparam logic [XLEN-1:0] KEEP = (XLEN'(1) << B_ME) | (XLEN'(1) << B_LE);

  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o); // R9

  AST_BUSY_WITH_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (exc_req_i || ret_req_i)) |=> !busy_o); // R9

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R6

  AST_MCHK_ME_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !busy_o && 6'(exc_cause_i) == C_MCHK)
      |=> (upd_o && !msr_o[B_ME])); // R6

  AST_NEW_MSR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !busy_o && 6'(exc_cause_i) != C_PROG)
      |=> ((msr_o & ~KEEP) == '0)); // R2

  AST_SAVE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !busy_o && 6'(exc_cause_i) != C_PROG)
      |=> ((save_msr_o & SAVE_CLR) == '0)); // R1

  AST_RET_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_req_i && !exc_req_i && !busy_o)
      |=> (upd_o && pc_o[1:0] == 2'b00)); // R8

  AST_VERR_WITH_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_err_o |-> upd_o); // R7
endmodule

bind exc_seq exc_seq_chk #(.CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  import exc_pkg::*;

  localparam logic [31:0] ME_B = 32'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0, ret_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cause = '0;
  logic [1:0]  sub = '0;
  logic [31:0] pc = '0, msr = '0, cfg_wd = '0;
  logic [6:0]  cfg_ad = '0;
  logic        busy, upd, verr, halt;
  logic [31:0] pc_o, msr_o, spc_o, smsr_o;

  always #4 clk = ~clk;

  exc_seq u_exc_seq (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .exc_cause_i(cause),
    .exc_sub_i(sub), .ret_req_i(ret_req), .pc_i(pc), .msr_i(msr),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_ad), .cfg_wdata_i(cfg_wd),
    .busy_o(busy), .upd_o(upd), .pc_o(pc_o), .msr_o(msr_o),
    .save_pc_o(spc_o), .save_msr_o(smsr_o), .vec_err_o(verr), .halt_o(halt)
  );

  typedef struct {
    logic [31:0] pc, msr, s0, s1;
    logic        verr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_err = 0;
  logic [31:0] m_tab [64];
  logic [31:0] m_pre = '0, m_s0 = '0, m_s1 = '0;
  logic        m_halt = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (sb.size() == 0) begin
        chk("R9 unexpected update", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " pc"}, pc_o, e.pc);
        chk({e.tag, " msr"}, msr_o, e.msr);
        chk({e.tag, " save0"}, spc_o, e.s0);
        chk({e.tag, " save1"}, smsr_o, e.s1);
        chk({e.tag, " verr"}, 32'(verr), 32'(e.verr));
      end
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ad = a; cfg_wd = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a[6]) m_pre = d; else m_tab[a[5:0]] = d;
  endtask

  // independent model of entry; returns 1 when the request is dropped
  function automatic logic model(input string tag, input logic [5:0] c,
                                 input logic [1:0] s, input logic [31:0] p,
                                 input logic [31:0] m);
    exp_t e;
    logic cur;
    e.s1 = m & 32'h87C0_FFFF;
    e.msr = (m & ME_B) | {31'd0, m[16]};
    cur = 1'b0;
    if (c == 6'd1) begin
      e.msr = e.msr & ~ME_B;
      if (!m[12]) m_halt = 1'b1;
    end
    if (c == 6'd5 || c == 6'd7) cur = 1'b1;
    if (c == 6'd6) begin
      case (s)
        2'd0: begin
          if (!m[13] || (!m[11] && !m[8])) return 1'b1;
          e.s1 |= 32'h0010_0000;
          if (m[11] != m[8]) begin e.s1 |= 32'h0001_0000; cur = 1'b1; end
        end
        2'd1: begin e.s1 |= 32'h0008_0000; cur = 1'b1; end
        2'd2: begin e.s1 |= 32'h0004_0000; cur = 1'b1; end
        default: begin e.s1 |= 32'h0002_0000; cur = 1'b1; end
      endcase
    end
    e.s0 = cur ? p - 32'd4 : p;
    e.pc = m_tab[c] | m_pre;
    e.verr = (m_tab[c] == 32'hFFFF_FFFF);
    e.tag = tag;
    m_s0 = e.s0; m_s1 = e.s1;
    sb.push_back(e);
    return 1'b0;
  endfunction

  task automatic exc(string tag, logic [5:0] c, logic [1:0] s,
                     logic [31:0] p, logic [31:0] m);
    logic dr;
    dr = model(tag, c, s, p, m);
    @(posedge clk); #1;
    exc_req = 1'b1; cause = c; sub = s; pc = p; msr = m;
    @(posedge clk); #1;
    exc_req = 1'b0;
    @(posedge clk);
  endtask

  task automatic ret(string tag);
    exp_t e;
    e.pc = {m_s0[31:2], 2'b00}; e.msr = m_s1 & 32'h87C0_FFFF;
    e.s0 = m_s0; e.s1 = m_s1; e.verr = 1'b0; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    ret_req = 1'b1;
    @(posedge clk); #1;
    ret_req = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_tab[i] = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset pc", pc_o, 32'd0);
    chk("R10 reset msr", msr_o, 32'd0);
    chk("R10 reset save0", spc_o, 32'd0);
    chk("R10 reset flags", {28'd0, busy, upd, verr, halt}, 32'd0);

    // R7 R10: unwritten entry is undefined
    exc("R7 undefined vector", 6'd2, 2'd0, 32'h0000_4000, 32'h0000_1000);

    wr(7'd2, 32'h0000_0300);
    wr(7'd1, 32'h0000_0200);
    wr(7'd5, 32'h0000_0600);
    wr(7'd6, 32'h0000_0700);
    wr(7'd7, 32'h0000_0800);
    wr(7'd9, 32'h0000_0900);
    wr(7'h40, 32'hFFF0_0000);

    exc("R1 R2 all ones msr", 6'd2, 2'd0, 32'h0000_5000, 32'hFFFF_FFFF);
    exc("R2 no ILE", 6'd9, 2'd0, 32'h0000_5100, 32'h0000_EFFF);
    exc("R3 align", 6'd5, 2'd0, 32'h0000_1000, 32'h0001_1000);
    exc("R3 fpu", 6'd7, 2'd0, 32'h0000_2000, 32'h0000_0000);
    exc("R4 illegal", 6'd6, 2'd1, 32'h0000_3000, 32'h0000_1000);
    exc("R4 priv", 6'd6, 2'd2, 32'h0000_3004, 32'h0040_0000);
    exc("R4 trap", 6'd6, 2'd3, 32'h0000_3008, 32'h0000_0000);
    exc("R4 fp imprecise", 6'd6, 2'd0, 32'h0000_300C, 32'h0000_2800);
    exc("R3 fp precise next", 6'd6, 2'd0, 32'h0000_3010, 32'h0000_2900);

    // R5: dropped requests
    exc("R5 drop fp off", 6'd6, 2'd0, 32'h0000_7000, 32'h0000_0900);
    exc("R5 drop fe off", 6'd6, 2'd0, 32'h0000_7004, 32'h0000_2000);
    @(negedge clk);
    chk("R5 save0 kept", spc_o, m_s0);
    chk("R5 save1 kept", smsr_o, m_s1);

    // R8: return restores aligned address and masked msr
    exc("R8 setup", 6'd2, 2'd0, 32'h0000_1237, 32'hFFFF_0003);
    ret("R8 return");

    // R9: entry wins over return
    begin
      logic dr;
      dr = model("R9 priority", 6'd9, 2'd0, 32'h0000_8000, 32'h0000_1000);
      @(posedge clk); #1;
      exc_req = 1'b1; ret_req = 1'b1; cause = 6'd9; pc = 32'h0000_8000; msr = 32'h0000_1000;
      @(posedge clk); #1;
      exc_req = 1'b0; ret_req = 1'b0;
      @(posedge clk);
    end

    // R9: request held during busy is ignored
    begin
      logic dr;
      dr = model("R9 busy ignore", 6'd2, 2'd0, 32'h0000_9000, 32'h0000_0000);
      @(posedge clk); #1;
      exc_req = 1'b1; cause = 6'd2; pc = 32'h0000_9000; msr = 32'h0000_0000;
      @(posedge clk); #1;
      cause = 6'd5; pc = 32'h0000_A000;
      @(negedge clk);
      chk("R9 busy during update", 32'(busy), 32'd1);
      @(posedge clk); #1;
      exc_req = 1'b0;
      @(posedge clk);
    end

    // R6: machine check
    exc("R6 mchk enabled", 6'd1, 2'd0, 32'h0000_B000, 32'h0000_1000);
    @(negedge clk);
    chk("R6 no halt", 32'(halt), 32'd0);
    exc("R6 mchk disabled", 6'd1, 2'd0, 32'h0000_B100, 32'h0000_0000);
    repeat (3) @(negedge clk);
    chk("R6 halt sticky", 32'(halt), 32'(m_halt));

    repeat (2) @(negedge clk);
    chk("R9 scoreboard drained", 32'(sb.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule